// File: doc/BRIEF.md
# Byte-Window Source Flow Control

This block sits on the sending side of a packet link, between a packet producer and the link. It stops any packet that would overfill the receiver's buffer. It keeps a running total of bytes it has released and compares it with the latest consumed-byte total that the receiver reports back. The difference between the two is the number of bytes in flight. A new packet is released only if that number plus the new packet's length still fits inside a window of 8·2^N bytes, where N is a programmable exponent.

Software sets up the block over a simple strobe-addressed settings bus. Through that bus it sets the window exponent, selects which gating modes are enabled, and resets the transmit-side and receive-side counters separately. It also holds the acknowledgement-interval configuration, which the block hands unchanged to the receiver-side partner. That partner reports its consumed byte total each time the programmed number of bytes has drained. The typical interval is one sixteenth of the window.

Acknowledgements arrive as a single-cycle strobe that carries a 64-bit consumed-byte total. The output stream has one register stage and honours backpressure.

Top module: `byte_window_src_fc`

## Requirements
- R1: After synchronous reset, `out_tvalid`, `st_in_flight`, `st_blocked`, `st_ack_err` and `peer_ack_en` are all zero.
- R2: The first beat of a packet carries its length in bytes in `in_tdata[15:0]`. The window exponent N sits in bits [7:0] of settings offset 0, and the window is 8·2^N bytes. While gating is active, a packet starts only when the bytes in flight plus its length are less than or equal to the window. A packet that would reach the window exactly is allowed.
- R3: `st_in_flight` reports the total of released packet lengths minus the last accepted consumed-byte total, computed modulo 2^64. It is updated from registered state.
- R4: A first beat that does not fit is held: `in_tready` stays low and `st_blocked` is high. The packet proceeds without any other action once an acknowledgement frees enough room.
- R5: Gating is active only when bits [1:0] of settings offset 2 are both 1. With any other value, including bit 2 alone or bit 0 alone, packets pass regardless of the window.
- R6: An acknowledgement whose total is lower than the last accepted one leaves the in-flight count unchanged. It sets `st_ack_err`, which stays set until the receive side is cleared.
- R7: While bit 0 of settings offset 3 holds 1, the released-byte total is zero. While bit 0 of settings offset 4 holds 1, the acknowledged total and `st_ack_err` are zero. Software clears by writing 1 and then 0.
- R8: Settings offset 1 drives `peer_ack_en` from bit 31 and `peer_ack_bytes` from bits 30:0.
- R9: Beats leave in input order with data and `tlast` unchanged. While `out_tready` is low, a valid output beat stays valid and stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | SET_AW | Settings write address |
| set_data | input | 32 | Settings write data |
| in_tdata | input | DATA_W | Input stream data; first beat holds length in [15:0] |
| in_tlast | input | 1 | Input last beat of packet |
| in_tvalid | input | 1 | Input beat valid |
| in_tready | output | 1 | Input beat accepted |
| out_tdata | output | DATA_W | Output stream data |
| out_tlast | output | 1 | Output last beat |
| out_tvalid | output | 1 | Output beat valid |
| out_tready | input | 1 | Downstream ready |
| ack_valid | input | 1 | Consumed-byte report strobe |
| ack_count | input | CNT_W | Consumed-byte total reported by the receiver |
| st_in_flight | output | CNT_W | Bytes released but not yet acknowledged |
| st_blocked | output | 1 | A first beat is waiting for window room |
| st_ack_err | output | 1 | Sticky flag for a decreasing acknowledgement |
| peer_ack_en | output | 1 | Acknowledgement enable for the receiver side |
| peer_ack_bytes | output | 31 | Acknowledgement interval in bytes for the receiver side |

## Verification
The bench builds the block with 64-bit data and counters, a 16-bit length field and a reset exponent of 5. It then programs exponents 3 and 2, giving windows of 64 and 32 bytes. These small windows let a few short packets reach the exact-fit boundary, the one-beat-over refusal, and a held packet released by a later acknowledgement, all within tens of cycles. Because the counters are 64 bits wide, clearing only the transmit side leaves the acknowledged total ahead of the released total. That brings the modulo-2^64 in-flight value into view without sending 2^64 bytes.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
  localparam int SET_DW = 32;
  // settings offsets relative to BASE
  localparam int OFS_WINDOW = 0;
  localparam int OFS_ACKCFG = 1;
  localparam int OFS_ENABLE = 2;
  localparam int OFS_CLR_TX = 3;
  localparam int OFS_CLR_RX = 4;
endpackage

// File: rtl/fcw_cfg.sv
module fcw_cfg #(
  parameter int SET_AW      = 8,
  parameter int BASE        = 0,
  parameter int WIN_EXP_RST = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_stb,
  input  logic [SET_AW-1:0]         set_addr,
  input  logic [fcw_pkg::SET_DW-1:0] set_data,
  output logic [7:0]                win_exp,
  output logic                      ack_cfg_en,
  output logic [30:0]               ack_cfg_bytes,
  output logic                      gate_on,
  output logic                      clr_tx,
  output logic                      clr_rx
);
  import fcw_pkg::*;

  localparam logic [SET_AW-1:0] A_WINDOW = SET_AW'(BASE + OFS_WINDOW);
  localparam logic [SET_AW-1:0] A_ACKCFG = SET_AW'(BASE + OFS_ACKCFG);
  localparam logic [SET_AW-1:0] A_ENABLE = SET_AW'(BASE + OFS_ENABLE);
  localparam logic [SET_AW-1:0] A_CLR_TX = SET_AW'(BASE + OFS_CLR_TX);
  localparam logic [SET_AW-1:0] A_CLR_RX = SET_AW'(BASE + OFS_CLR_RX);

  logic [1:0] en_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_exp       <= 8'(WIN_EXP_RST);
      ack_cfg_en    <= 1'b0;
      ack_cfg_bytes <= '0;
      en_bits       <= 2'b00;
      clr_tx        <= 1'b0;
      clr_rx        <= 1'b0;
    end else if (set_stb) begin
      if (set_addr == A_WINDOW) win_exp <= set_data[7:0];
      if (set_addr == A_ACKCFG) begin
        ack_cfg_en    <= set_data[31];
        ack_cfg_bytes <= set_data[30:0];
      end
      if (set_addr == A_ENABLE) en_bits <= set_data[1:0];
      if (set_addr == A_CLR_TX) clr_tx <= set_data[0];
      if (set_addr == A_CLR_RX) clr_rx <= set_data[0];
    end
  end

  // both the flow-control bit and the byte-limit bit are required
  assign gate_on = en_bits[0] & en_bits[1];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !set_stb |=> $stable(win_exp) && $stable(ack_cfg_bytes) && $stable(gate_on)); // R8
endmodule

// File: rtl/fcw_ack.sv
module fcw_ack #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ack_valid,
  input  logic [CNT_W-1:0] ack_count,
  output logic [CNT_W-1:0] acked,
  output logic             err
);
  logic going_back;
  assign going_back = ack_valid && (ack_count < acked);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acked <= '0;
      err   <= 1'b0;
    end else if (ack_valid) begin
      if (going_back) err   <= 1'b1;
      else            acked <= ack_count;
    end
  end

  AST_ACK_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    !clr |=> acked >= $past(acked)); // R6
  AST_ACK_ERR_RAISED: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_count < acked && !clr) |=> err); // R6
  AST_ACK_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acked == '0) && !err); // R7
endmodule

// File: rtl/fcw_gate.sv
module fcw_gate #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 64,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_tx,
  input  logic              gate_on,
  input  logic [CNT_W-1:0]  window,
  input  logic [CNT_W-1:0]  acked,
  input  logic [DATA_W-1:0] in_tdata,
  input  logic              in_tlast,
  input  logic              in_tvalid,
  output logic              in_tready,
  output logic [DATA_W-1:0] out_tdata,
  output logic              out_tlast,
  output logic              out_tvalid,
  input  logic              out_tready,
  output logic [CNT_W-1:0]  bytes_sent,
  output logic              blocked
);
  logic             mid_pkt;
  logic [CNT_W-1:0] in_flight;
  logic [CNT_W-1:0] hdr_len;
  logic             room_ok;
  logic             out_free;
  logic             accept;

  assign in_flight = bytes_sent - acked;          // modulo 2^CNT_W
  assign hdr_len   = CNT_W'(in_tdata[LEN_W-1:0]);
  assign room_ok   = !gate_on || ((in_flight + hdr_len) <= window);
  assign out_free  = !out_tvalid || out_tready;
  assign in_tready = out_free && (mid_pkt || room_ok);
  assign accept    = in_tvalid && in_tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_tvalid <= 1'b0;
      out_tdata  <= '0;
      out_tlast  <= 1'b0;
      mid_pkt    <= 1'b0;
      bytes_sent <= '0;
      blocked    <= 1'b0;
    end else begin
      if (out_free) out_tvalid <= accept;
      if (accept) begin
        out_tdata <= in_tdata;
        out_tlast <= in_tlast;
        mid_pkt   <= !in_tlast;
      end
      if (clr_tx)                  bytes_sent <= '0;
      else if (accept && !mid_pkt) bytes_sent <= bytes_sent + hdr_len;
      blocked <= in_tvalid && !mid_pkt && !room_ok;
    end
  end

  AST_WINDOW_KEPT: assert property (@(posedge clk) disable iff (rst)
    (accept && !mid_pkt && gate_on && !clr_tx) |=>
      (bytes_sent - $past(acked)) <= $past(window)); // R2
  AST_SENT_GROWS: assert property (@(posedge clk) disable iff (rst)
    (accept && !mid_pkt && !clr_tx) |=> bytes_sent == $past(bytes_sent + hdr_len)); // R3
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_tvalid && !out_tready) |=> out_tvalid && $stable(out_tdata) && $stable(out_tlast)); // R9
  AST_TX_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_tx |=> bytes_sent == '0); // R7
endmodule

// File: rtl/byte_window_src_fc.sv
module byte_window_src_fc #(
  parameter int DATA_W      = 64,
  parameter int CNT_W       = 64,
  parameter int LEN_W       = 16,
  parameter int SET_AW      = 8,
  parameter int BASE        = 0,
  parameter int WIN_EXP_RST = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       set_stb,
  input  logic [SET_AW-1:0]          set_addr,
  input  logic [fcw_pkg::SET_DW-1:0] set_data,
  input  logic [DATA_W-1:0]          in_tdata,
  input  logic                       in_tlast,
  input  logic                       in_tvalid,
  output logic                       in_tready,
  output logic [DATA_W-1:0]          out_tdata,
  output logic                       out_tlast,
  output logic                       out_tvalid,
  input  logic                       out_tready,
  input  logic                       ack_valid,
  input  logic [CNT_W-1:0]           ack_count,
  output logic [CNT_W-1:0]           st_in_flight,
  output logic                       st_blocked,
  output logic                       st_ack_err,
  output logic                       peer_ack_en,
  output logic [30:0]                peer_ack_bytes
);
  localparam logic [CNT_W-1:0] LINE_BYTES = CNT_W'(8);

  logic [7:0]       win_exp;
  logic             gate_on;
  logic             clr_tx;
  logic             clr_rx;
  logic [CNT_W-1:0] window;
  logic [CNT_W-1:0] acked;
  logic [CNT_W-1:0] bytes_sent;

  fcw_cfg #(.SET_AW(SET_AW), .BASE(BASE), .WIN_EXP_RST(WIN_EXP_RST)) u_cfg (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
    .win_exp(win_exp), .ack_cfg_en(peer_ack_en), .ack_cfg_bytes(peer_ack_bytes),
    .gate_on(gate_on), .clr_tx(clr_tx), .clr_rx(clr_rx));

  // window of 8 * 2^N bytes
  assign window = LINE_BYTES << win_exp;

  fcw_ack #(.CNT_W(CNT_W)) u_ack (
    .clk(clk), .rst(rst), .clr(clr_rx), .ack_valid(ack_valid), .ack_count(ack_count),
    .acked(acked), .err(st_ack_err));

  fcw_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_gate (
    .clk(clk), .rst(rst), .clr_tx(clr_tx), .gate_on(gate_on), .window(window),
    .acked(acked), .in_tdata(in_tdata), .in_tlast(in_tlast), .in_tvalid(in_tvalid),
    .in_tready(in_tready), .out_tdata(out_tdata), .out_tlast(out_tlast),
    .out_tvalid(out_tvalid), .out_tready(out_tready), .bytes_sent(bytes_sent),
    .blocked(st_blocked));

  always_ff @(posedge clk) begin
    if (rst) st_in_flight <= '0;
    else     st_in_flight <= bytes_sent - acked;
  end

  AST_FLIGHT_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (!set_stb && !ack_valid && !in_tvalid) |=>
      st_in_flight == $past(bytes_sent) - $past(acked)); // R3
endmodule

// File: tb/sim_byte_window_src_fc.sv
`timescale 1ns/1ps
module sim_byte_window_src_fc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_stb = 1'b0;
  logic [7:0]  set_addr = '0;
  logic [31:0] set_data = '0;
  logic [63:0] in_tdata = '0;
  logic        in_tlast = 1'b0;
  logic        in_tvalid = 1'b0;
  logic        in_tready;
  logic [63:0] out_tdata;
  logic        out_tlast;
  logic        out_tvalid;
  logic        out_tready = 1'b1;
  logic        ack_valid = 1'b0;
  logic [63:0] ack_count = '0;
  logic [63:0] st_in_flight;
  logic        st_blocked;
  logic        st_ack_err;
  logic        peer_ack_en;
  logic [30:0] peer_ack_bytes;

  always #2.5 clk = ~clk;

  byte_window_src_fc #(.DATA_W(64), .CNT_W(64), .LEN_W(16), .SET_AW(8), .BASE(0),
                       .WIN_EXP_RST(5)) u0 (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
    .in_tdata(in_tdata), .in_tlast(in_tlast), .in_tvalid(in_tvalid), .in_tready(in_tready),
    .out_tdata(out_tdata), .out_tlast(out_tlast), .out_tvalid(out_tvalid),
    .out_tready(out_tready), .ack_valid(ack_valid), .ack_count(ack_count),
    .st_in_flight(st_in_flight), .st_blocked(st_blocked), .st_ack_err(st_ack_err),
    .peer_ack_en(peer_ack_en), .peer_ack_bytes(peer_ack_bytes));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int pkt_id = 0;

  // beat log for order/data checking
  logic [64:0] in_log  [0:1023];
  logic [64:0] out_log [0:1023];
  int n_in = 0;
  int n_out = 0;

  always @(negedge clk) begin
    if (!rst && in_tvalid && in_tready && n_in < 1024) begin
      in_log[n_in] = {in_tlast, in_tdata};
      n_in++;
    end
    if (!rst && out_tvalid && out_tready && n_out < 1024) begin
      out_log[n_out] = {out_tlast, out_tdata};
      n_out++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    set_stb = 1'b1; set_addr = a; set_data = d;
    @(posedge clk); #1;
    set_stb = 1'b0;
  endtask

  task automatic do_ack(input logic [63:0] v);
    @(posedge clk); #1;
    ack_valid = 1'b1; ack_count = v;
    @(posedge clk); #1;
    ack_valid = 1'b0;
  endtask

  task automatic settle;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] hdr_word(input int id, input int lines);
    return {16'hC0DE, 16'(id), 16'h0000, 16'(lines * 8)};
  endfunction

  // offers a packet of 'lines' beats; length field = 8*lines bytes
  task automatic send_pkt(input int lines, input int tmo, output bit ok);
    int waited;
    ok = 1'b1;
    @(posedge clk); #1;
    for (int b = 0; b < lines; b++) begin
      in_tvalid = 1'b1;
      in_tdata  = (b == 0) ? hdr_word(pkt_id, lines) : {32'(pkt_id), 32'(b)};
      in_tlast  = (b == lines - 1);
      waited = 0;
      forever begin
        @(negedge clk);
        if (in_tready) break;
        waited++;
        if (waited >= tmo) begin ok = 1'b0; break; end
      end
      if (!ok) break;
      @(posedge clk); #1;
    end
    in_tvalid = 1'b0;
    in_tlast  = 1'b0;
    pkt_id++;
  endtask

  // {has_ack, ack[31:0], lines[7:0], pass, flight[31:0]} ; window = 64 bytes
  localparam logic [73:0] TBL [8] = '{
    {1'b0, 32'd0,   8'd4, 1'b1, 32'd32},
    {1'b0, 32'd0,   8'd4, 1'b1, 32'd64},
    {1'b0, 32'd0,   8'd1, 1'b0, 32'd64},
    {1'b1, 32'd16,  8'd2, 1'b1, 32'd64},
    {1'b1, 32'd40,  8'd3, 1'b1, 32'd64},
    {1'b1, 32'd104, 8'd8, 1'b1, 32'd64},
    {1'b1, 32'd168, 8'd1, 1'b1, 32'd8},
    {1'b1, 32'd176, 8'd9, 1'b0, 32'd0}
  };

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit ok;
    logic [63:0] hdr_exp;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_tvalid", 64'(out_tvalid), 64'd0);
    chk("R1 st_in_flight", st_in_flight, 64'd0);
    chk("R1 st_ack_err", 64'(st_ack_err), 64'd0);
    chk("R1 st_blocked", 64'(st_blocked), 64'd0);
    chk("R1 peer_ack_en", 64'(peer_ack_en), 64'd0);

    wr(8'd0, 32'd3);   // window 64 bytes
    wr(8'd2, 32'd3);   // gating on

    // table walk: R2 window boundary, R3 in-flight arithmetic
    for (int i = 0; i < 8; i++) begin
      logic [73:0] row;
      row = TBL[i];
      if (row[73]) do_ack(64'(row[72:41]));
      send_pkt(int'(row[40:33]), 20, ok);
      settle();
      chk($sformatf("R2 row%0d pass", i), 64'(ok), 64'(row[32]));
      chk($sformatf("R3 row%0d in_flight", i), st_in_flight, 64'(row[31:0]));
    end

    // R4 held packet released by acknowledgement
    send_pkt(8, 20, ok);
    settle();
    chk("R4 fill pass", 64'(ok), 64'd1);
    chk("R4 fill in_flight", st_in_flight, 64'd64);
    fork
      send_pkt(2, 200, ok);
      begin
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R4 st_blocked", 64'(st_blocked), 64'd1);
        chk("R4 in_tready held", 64'(in_tready), 64'd0);
        do_ack(64'd232);
      end
    join
    settle();
    chk("R4 released", 64'(ok), 64'd1);
    chk("R4 in_flight", st_in_flight, 64'd24);
    chk("R4 unblocked", 64'(st_blocked), 64'd0);

    // R6 lower acknowledgement ignored
    do_ack(64'd100);
    settle();
    chk("R6 st_ack_err", 64'(st_ack_err), 64'd1);
    chk("R6 in_flight kept", st_in_flight, 64'd24);

    // R5 enable combinations
    wr(8'd2, 32'd0);
    send_pkt(16, 20, ok);
    settle();
    chk("R5 off pass", 64'(ok), 64'd1);
    chk("R5 off in_flight", st_in_flight, 64'd152);
    wr(8'd2, 32'd4);
    send_pkt(16, 20, ok);
    settle();
    chk("R5 bit2 pass", 64'(ok), 64'd1);
    wr(8'd2, 32'd1);
    send_pkt(1, 20, ok);
    settle();
    chk("R5 bit0 pass", 64'(ok), 64'd1);
    chk("R5 bit0 in_flight", st_in_flight, 64'd288);
    wr(8'd2, 32'd3);
    send_pkt(1, 20, ok);
    settle();
    chk("R5 on blocks", 64'(ok), 64'd0);

    // R7 separate clears; R3 wrap-safe difference
    wr(8'd3, 32'd1);
    wr(8'd3, 32'd0);
    settle();
    chk("R7 tx clear, R3 wrap", st_in_flight, 64'd0 - 64'd232);
    chk("R7 err kept on tx clear", 64'(st_ack_err), 64'd1);
    wr(8'd4, 32'd1);
    wr(8'd4, 32'd0);
    settle();
    chk("R7 rx clear in_flight", st_in_flight, 64'd0);
    chk("R7 rx clear err", 64'(st_ack_err), 64'd0);

    // R2 with a 32-byte window
    wr(8'd0, 32'd2);
    send_pkt(4, 20, ok);
    settle();
    chk("R2 exp2 exact fit", 64'(ok), 64'd1);
    send_pkt(1, 20, ok);
    settle();
    chk("R2 exp2 over", 64'(ok), 64'd0);

    // R8 peer acknowledgement configuration
    wr(8'd1, 32'h8000_0004);
    settle();
    chk("R8 peer_ack_en", 64'(peer_ack_en), 64'd1);
    chk("R8 peer_ack_bytes", 64'(peer_ack_bytes), 64'd4);
    wr(8'd1, 32'h0000_0010);
    settle();
    chk("R8 peer_ack_en off", 64'(peer_ack_en), 64'd0);
    chk("R8 peer_ack_bytes 16", 64'(peer_ack_bytes), 64'd16);

    // R9 backpressure
    do_ack(64'd32);
    @(posedge clk); #1 out_tready = 1'b0;
    hdr_exp = hdr_word(pkt_id, 3);
    fork
      send_pkt(3, 50, ok);
      begin
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk("R9 held valid", 64'(out_tvalid), 64'd1);
        chk("R9 held data", out_tdata, hdr_exp);
        @(posedge clk); #1 out_tready = 1'b1;
      end
    join
    settle();
    chk("R9 backpressure pass", 64'(ok), 64'd1);

    // R9 order and content
    chk("R9 beat count", 64'(n_out), 64'(n_in));
    begin
      int mism;
      mism = 0;
      for (int k = 0; k < n_in && k < n_out; k++)
        if (in_log[k] !== out_log[k]) mism++;
      chk("R9 beat content", 64'(mism), 64'd0);
    end
    finish_run();
  end
endmodule